// File: doc/BRIEF.md
# LPC Bus Register Target

This block is a peripheral target on a Low Pin Count bus, clocked by the bus clock. It decodes host I/O and memory cycles, both reads and writes, from the 4-bit multiplexed LAD lines. A cycle starts when the frame strobe is low and LAD carries the start code. Each claimed cycle becomes one request to an internal register port. That port is slow, and its response time depends on the address. While the request is pending, the target holds the host with long-wait SYNC codes. When the access completes, it sends the ready SYNC, then the read data if the cycle was a read, and then it turns the bus around.

A small byte-wide register array stands in for the shared internal bus. Its latency is `LAT_BASE + addr[2:0]` clocks, so the number of wait SYNCs can be predicted from the address alone. The target also watches the bus power-down input. While that input is low, the target stays silent and decodes nothing. When it returns high, the target decodes normally again and the register contents are unchanged. The bus reset input clears both the target and the register array.

Top module: `lpc_target`

## Requirements
- R1: An I/O cycle is claimed when the nibble after START has LAD[3:2]=00. LAD[1] gives the direction (1 = write). Four address nibbles follow, most significant first.
- R2: A memory cycle is claimed when the nibble after START has LAD[3:2]=01. It carries eight address nibbles, most significant first, and is otherwise the same as an I/O cycle.
- R3: After the two host turnaround clocks, the target drives at least two long-wait SYNCs (0110) before the ready SYNC (0000). The wait count is max(2, addr[2:0]+1).
- R4: The target never drives more than 8 long-wait SYNCs in one cycle. In the SYNC phase it drives only 0110 or 0000: no short-wait code and no error code.
- R5: After the ready SYNC of a read, the target drives the data byte low nibble first. It then drives 1111 for one clock and floats LAD on the next clock.
- R6: Write data arrives low nibble first right after the address. It is stored at byte index addr[3:0] and can be read back. After the ready SYNC of a write, the turnaround follows at once.
- R7: START is the frame strobe low with LAD=0000. The frame strobe low with any other LAD value aborts the cycle in progress, and LAD is released from the next clock.
- R8: A cycle whose type nibble has LAD[3] set is not claimed, and LAD stays released.
- R9: While the power-down input is low, bus activity is ignored: there is no response and no register change. After it returns high, decoding resumes with the register contents kept.
- R10: A low bus reset releases LAD at once, returns the target to idle and clears every register byte to zero.
- R11: LAD is driven only during the SYNC, read-data and first target-turnaround clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Bus reset, active low, asynchronous |
| lframe_ni | input | 1 | Frame strobe, active low |
| lad_i | input | 4 | LAD value sampled from the bus |
| lpcpd_ni | input | 1 | Bus power-down, active low |
| lad_o | output | 4 | LAD value driven by the target |
| lad_oe_o | output | 1 | LAD output enable |

## Verification
The bench sweeps the latency-selecting address bits from 0 to 7. A target that issued only one wait, used the short-wait code, or cut the response short is caught by the exact count of long-wait clocks, which reaches 8 at the top of the sweep. Aborts are applied in the middle of the address phase and in the middle of the SYNC phase. A design that kept driving LAD, or that completed a partial write, shows up on the following clocks and on a later readback. A write sent while power-down is low must leave the byte unchanged. A reset applied during SYNC must release LAD within the same clock and clear the register contents.

// File: rtl/lpc_target_pkg.sv
package lpc_target_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_CTYPE, ST_ADDR, ST_WDATA, ST_HTAR,
    ST_SYNC, ST_RDATA, ST_TTAR1, ST_TTAR2
  } lpc_state_e;

  localparam logic [3:0] LAD_START  = 4'h0;
  localparam logic [3:0] SYNC_READY = 4'h0;
  localparam logic [3:0] SYNC_LWAIT = 4'h6;
  localparam logic [3:0] LAD_TAR    = 4'hF;
  localparam logic [1:0] CT_IO      = 2'b00;
  localparam logic [1:0] CT_MEM     = 2'b01;
endpackage

// File: rtl/lpc_reg_stub.sv
module lpc_reg_stub #(
  parameter int DEPTH     = 16,
  parameter int LAT_BASE  = 2,
  parameter int LAT_SEL_W = 3,
  localparam int IDX_W    = $clog2(DEPTH),
  localparam int CNT_W    = $clog2(LAT_BASE + (1 << LAT_SEL_W))
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             we_i,
  input  logic [IDX_W-1:0] addr_i,
  input  logic [7:0]       wdata_i,
  output logic             ack_o,
  output logic [7:0]       rdata_o
);
  logic [7:0]       mem_q [DEPTH];
  logic             busy_q, we_q;
  logic [CNT_W-1:0] cnt_q;
  logic [IDX_W-1:0] idx_q;
  logic [7:0]       wd_q;

  assign ack_o   = busy_q && (cnt_q == '0);
  assign rdata_o = mem_q[idx_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      we_q   <= 1'b0;
      cnt_q  <= '0;
      idx_q  <= '0;
      wd_q   <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (req_i) begin
      // a new request cancels any leftover one from an aborted cycle
      busy_q <= 1'b1;
      we_q   <= we_i;
      idx_q  <= addr_i;
      wd_q   <= wdata_i;
      cnt_q  <= CNT_W'(LAT_BASE) + CNT_W'(addr_i[LAT_SEL_W-1:0]);
    end else if (ack_o) begin
      busy_q <= 1'b0;
      if (we_q) mem_q[idx_q] <= wd_q;
    end else if (busy_q) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assert_ack_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ack_o);
endmodule

// File: rtl/lpc_cycle_fsm.sv
module lpc_cycle_fsm
  import lpc_target_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int MIN_WAIT = 2,
  parameter int MAX_WAIT = 8,
  localparam int WCNT_W  = $clog2(MAX_WAIT + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lframe_ni,
  input  logic [3:0]        lad_i,
  input  logic              lpcpd_ni,
  output logic [3:0]        lad_o,
  output logic              lad_oe_o,
  output logic              req_o,
  output logic              we_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [7:0]        wdata_o,
  input  logic              ack_i,
  input  logic [7:0]        rdata_i
);
  lpc_state_e        state_q, state_d;
  logic [2:0]        nib_q, nib_d;
  logic              wr_q, wr_d, done_q, done_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [7:0]        data_q, data_d;
  logic [WCNT_W-1:0] wait_q, wait_d;
  logic              ready_c;

  assign ready_c = (ack_i || done_q) && (wait_q >= WCNT_W'(MIN_WAIT));

  always_comb begin
    state_d = state_q;
    nib_d   = nib_q;
    wr_d    = wr_q;
    done_d  = done_q;
    addr_d  = addr_q;
    data_d  = data_q;
    wait_d  = wait_q;
    if (!lpcpd_ni) begin
      state_d = ST_IDLE;
    end else if (!lframe_ni) begin
      state_d = (lad_i == LAD_START) ? ST_CTYPE : ST_IDLE;
    end else begin
      unique case (state_q)
        ST_CTYPE: begin
          wr_d   = lad_i[1];
          addr_d = '0;
          if (lad_i[3:2] == CT_IO) begin
            nib_d = 3'd3;  state_d = ST_ADDR;
          end else if (lad_i[3:2] == CT_MEM) begin
            nib_d = 3'd7;  state_d = ST_ADDR;
          end else begin
            state_d = ST_IDLE;
          end
        end
        ST_ADDR: begin
          addr_d = ADDR_W'({addr_q, lad_i});
          if (nib_q == 3'd0) begin
            state_d = wr_q ? ST_WDATA : ST_HTAR;
          end else begin
            nib_d = nib_q - 3'd1;
          end
        end
        ST_WDATA: begin
          if (nib_q == 3'd0) begin
            data_d[3:0] = lad_i;  nib_d = 3'd1;
          end else begin
            data_d[7:4] = lad_i;  nib_d = 3'd0;  state_d = ST_HTAR;
          end
        end
        ST_HTAR: begin
          done_d = 1'b0;
          wait_d = '0;
          if (nib_q == 3'd0) nib_d = 3'd1;
          else begin
            nib_d = 3'd0;  state_d = ST_SYNC;
          end
        end
        ST_SYNC: begin
          if (ack_i) begin
            done_d = 1'b1;
            if (!wr_q) data_d = rdata_i;
          end
          if (ready_c) state_d = wr_q ? ST_TTAR1 : ST_RDATA;
          else wait_d = wait_q + 1'b1;
        end
        ST_RDATA: begin
          if (nib_q == 3'd0) nib_d = 3'd1;
          else begin
            nib_d = 3'd0;  state_d = ST_TTAR1;
          end
        end
        ST_TTAR1: state_d = ST_TTAR2;
        ST_TTAR2: state_d = ST_IDLE;
        default:  state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      nib_q   <= '0;
      wr_q    <= 1'b0;
      done_q  <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
      wait_q  <= '0;
    end else begin
      state_q <= state_d;
      nib_q   <= nib_d;
      wr_q    <= wr_d;
      done_q  <= done_d;
      addr_q  <= addr_d;
      data_q  <= data_d;
      wait_q  <= wait_d;
    end
  end

  always_comb begin
    lad_oe_o = 1'b0;
    lad_o    = LAD_TAR;
    unique case (state_q)
      ST_SYNC: begin
        lad_oe_o = 1'b1;
        lad_o    = ready_c ? SYNC_READY : SYNC_LWAIT;
      end
      ST_RDATA: begin
        lad_oe_o = 1'b1;
        lad_o    = nib_q[0] ? data_q[7:4] : data_q[3:0];
      end
      ST_TTAR1: lad_oe_o = 1'b1;
      default: ;
    endcase
  end

  assign req_o   = (state_q == ST_HTAR) && (nib_q == 3'd0);
  assign we_o    = wr_q;
  assign addr_o  = addr_q;
  assign wdata_o = data_q;

  assert_first_wait_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SYNC && $past(state_q) == ST_HTAR) |-> lad_o == SYNC_LWAIT);
  assert_second_wait_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SYNC && $past(state_q) == ST_SYNC && $past(state_q, 2) == ST_HTAR)
      |-> lad_o == SYNC_LWAIT);
  assert_wait_cap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SYNC) |-> wait_q <= WCNT_W'(MAX_WAIT));
  assert_sync_code_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SYNC) |-> (lad_o == SYNC_LWAIT || lad_o == SYNC_READY));
  assert_abort_release_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lpcpd_ni && !lframe_ni && lad_i != LAD_START) |=> !lad_oe_o);
  assert_pd_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lpcpd_ni |=> !lad_oe_o);
endmodule

// File: rtl/lpc_target.sv
module lpc_target #(
  parameter int DEPTH     = 16,
  parameter int MIN_WAIT  = 2,
  parameter int MAX_WAIT  = 8,
  parameter int LAT_BASE  = 2,
  parameter int LAT_SEL_W = 3
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       lframe_ni,
  input  logic [3:0] lad_i,
  input  logic       lpcpd_ni,
  output logic [3:0] lad_o,
  output logic       lad_oe_o
);
  localparam int IDX_W = $clog2(DEPTH);

  logic             req, we, ack;
  logic [IDX_W-1:0] addr;
  logic [7:0]       wdata, rdata;

  lpc_cycle_fsm #(
    .ADDR_W(IDX_W), .MIN_WAIT(MIN_WAIT), .MAX_WAIT(MAX_WAIT)
  ) u_fsm (
    .clk_i, .rst_ni, .lframe_ni, .lad_i, .lpcpd_ni,
    .lad_o, .lad_oe_o,
    .req_o(req), .we_o(we), .addr_o(addr), .wdata_o(wdata),
    .ack_i(ack), .rdata_i(rdata)
  );

  lpc_reg_stub #(
    .DEPTH(DEPTH), .LAT_BASE(LAT_BASE), .LAT_SEL_W(LAT_SEL_W)
  ) u_regs (
    .clk_i, .rst_ni,
    .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .ack_o(ack), .rdata_o(rdata)
  );
endmodule

// File: tb/lpc_target_tb.sv
module lpc_target_tb_top;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst_n, lframe_n, lpcpd_n;
  logic [3:0] lad;
  logic [3:0] lad_o;
  logic       lad_oe;
  int         checks = 0, fails = 0;
  logic [7:0] model [16];

  always #(CLK_PERIOD/2) clk = ~clk;

  lpc_target dut_i (
    .clk_i(clk), .rst_ni(rst_n), .lframe_ni(lframe_n), .lad_i(lad),
    .lpcpd_ni(lpcpd_n), .lad_o(lad_o), .lad_oe_o(lad_oe)
  );

  task automatic chk(string req, logic oe_e, logic [3:0] lad_e);
    checks++;
    if (lad_oe !== oe_e || (oe_e && lad_o !== lad_e)) begin
      fails++;
      $display("FAIL %s: oe=%b lad=%h expected oe=%b lad=%h", req, lad_oe, lad_o, oe_e, lad_e);
    end
  endtask

  // one bus clock: drive inputs at negedge, compare outputs of that clock
  task automatic cyc(logic lf, logic [3:0] l, logic oe_e, logic [3:0] lad_e, string req);
    @(negedge clk);
    lframe_n = lf;
    lad      = l;
    chk(req, oe_e, lad_e);
  endtask

  task automatic idle(int n, string req);
    for (int i = 0; i < n; i++) cyc(1'b1, 4'hF, 1'b0, 4'h0, req);
  endtask

  task automatic host(bit mem, bit wr, logic [31:0] a, logic [7:0] d, bit quiet, string req);
    int nn, w;
    logic [7:0] rb;
    cyc(1'b0, 4'h0, 1'b0, 4'h0, "R11");
    cyc(1'b1, {mem ? 2'b01 : 2'b00, wr, 1'b0}, 1'b0, 4'h0, "R11");
    nn = mem ? 8 : 4;
    for (int i = nn - 1; i >= 0; i--) cyc(1'b1, a[4*i +: 4], 1'b0, 4'h0, "R11");
    if (wr) begin
      cyc(1'b1, d[3:0], 1'b0, 4'h0, "R6");
      cyc(1'b1, d[7:4], 1'b0, 4'h0, "R6");
    end
    cyc(1'b1, 4'hF, 1'b0, 4'h0, "R11");
    cyc(1'b1, 4'hF, 1'b0, 4'h0, "R11");
    if (quiet) begin
      idle(12, req);
      return;
    end
    w = (int'(a[2:0]) + 1 > 2) ? int'(a[2:0]) + 1 : 2;
    for (int i = 0; i < w; i++) cyc(1'b1, 4'hF, 1'b1, 4'h6, "R3");
    cyc(1'b1, 4'hF, 1'b1, 4'h0, "R4");
    if (wr) model[a[3:0]] = d;
    else begin
      rb = model[a[3:0]];
      cyc(1'b1, 4'hF, 1'b1, rb[3:0], req);
      cyc(1'b1, 4'hF, 1'b1, rb[7:4], req);
    end
    cyc(1'b1, 4'hF, 1'b1, 4'hF, "R5");
    cyc(1'b1, 4'hF, 1'b0, 4'h0, "R5");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: oe=%b lad=%h expected oe=0 lad=0", lad_oe, lad_o);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) model[i] = 8'h00;
    rst_n = 1'b0; lframe_n = 1'b1; lpcpd_n = 1'b1; lad = 4'hF;
    repeat (3) @(negedge clk);
    chk("R10", 1'b0, 4'h0);
    rst_n = 1'b1;
    idle(2, "R11");

    // R1 I/O write then read, 6 waits
    host(1'b0, 1'b1, 32'h0005, 8'hA5, 1'b0, "R6");
    host(1'b0, 1'b0, 32'h0005, 8'h00, 1'b0, "R1");
    // R2 memory cycles, 2 waits and 8 waits
    host(1'b1, 1'b1, 32'h1234_5678, 8'h3C, 1'b0, "R2");
    host(1'b1, 1'b1, 32'hFEDC_BA9F, 8'hC3, 1'b0, "R2");
    host(1'b1, 1'b0, 32'h1234_5678, 8'h00, 1'b0, "R2");
    host(1'b1, 1'b0, 32'hFEDC_BA9F, 8'h00, 1'b0, "R2");
    // R3/R4 wait count sweep over latency bits
    for (int k = 0; k < 8; k++) host(1'b0, 1'b0, 32'(k), 8'h00, 1'b0, "R3");
    host(1'b0, 1'b1, 32'h0003, 8'h5A, 1'b0, "R6");
    host(1'b0, 1'b0, 32'h0003, 8'h00, 1'b0, "R6");

    // R7 abort in address phase: partial write must not land
    cyc(1'b0, 4'h0, 1'b0, 4'h0, "R7");
    cyc(1'b1, 4'b0010, 1'b0, 4'h0, "R7");
    cyc(1'b1, 4'h0, 1'b0, 4'h0, "R7");
    cyc(1'b1, 4'h0, 1'b0, 4'h0, "R7");
    cyc(1'b0, 4'hF, 1'b0, 4'h0, "R7");
    idle(12, "R7");
    host(1'b0, 1'b0, 32'h0003, 8'h00, 1'b0, "R7");

    // R7 abort during SYNC of a slow read
    cyc(1'b0, 4'h0, 1'b0, 4'h0, "R7");
    cyc(1'b1, 4'b0000, 1'b0, 4'h0, "R7");
    for (int i = 3; i >= 0; i--) cyc(1'b1, (i == 0) ? 4'h7 : 4'h0, 1'b0, 4'h0, "R7");
    cyc(1'b1, 4'hF, 1'b0, 4'h0, "R7");
    cyc(1'b1, 4'hF, 1'b0, 4'h0, "R7");
    for (int i = 0; i < 3; i++) cyc(1'b1, 4'hF, 1'b1, 4'h6, "R3");
    cyc(1'b0, 4'hF, 1'b1, 4'h6, "R7");
    idle(12, "R7");

    // R8 unsupported cycle type
    cyc(1'b0, 4'h0, 1'b0, 4'h0, "R8");
    cyc(1'b1, 4'b1000, 1'b0, 4'h0, "R8");
    for (int i = 0; i < 8; i++) cyc(1'b1, 4'h0, 1'b0, 4'h0, "R8");
    idle(12, "R8");

    // R9 power-down: write ignored, contents kept afterwards
    @(negedge clk); lpcpd_n = 1'b0;
    host(1'b0, 1'b1, 32'h0005, 8'h11, 1'b1, "R9");
    host(1'b0, 1'b0, 32'h0005, 8'h00, 1'b1, "R9");
    @(negedge clk); lpcpd_n = 1'b1;
    idle(2, "R9");
    host(1'b0, 1'b0, 32'h0005, 8'h00, 1'b0, "R9");

    // R10 reset in SYNC: immediate release, contents cleared
    cyc(1'b0, 4'h0, 1'b0, 4'h0, "R10");
    cyc(1'b1, 4'b0000, 1'b0, 4'h0, "R10");
    for (int i = 3; i >= 0; i--) cyc(1'b1, (i == 0) ? 4'h6 : 4'h0, 1'b0, 4'h0, "R10");
    cyc(1'b1, 4'hF, 1'b0, 4'h0, "R10");
    cyc(1'b1, 4'hF, 1'b0, 4'h0, "R10");
    cyc(1'b1, 4'hF, 1'b1, 4'h6, "R10");
    #(CLK_PERIOD/4);
    rst_n = 1'b0;
    #1;
    chk("R10", 1'b0, 4'h0);
    for (int i = 0; i < 16; i++) model[i] = 8'h00;
    @(negedge clk); rst_n = 1'b1;
    idle(2, "R10");
    host(1'b0, 1'b0, 32'h0005, 8'h00, 1'b0, "R10");
    host(1'b1, 1'b0, 32'hFEDC_BA9F, 8'h00, 1'b0, "R10");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule